// File: doc/BRIEF.md
# Multi-path pipeline interlock unit

This unit decides, for the instruction sitting in decode of an in-order pipeline, whether that instruction may move on into the first of two register-read stages. When bypassing is built in, it also decides where each source operand will come from. Past the shared front end (fetch, micro-op conversion, decode, two register-read stages) an instruction follows one of three execution paths. An integer add uses one integer-ALU stage. A load or store uses an integer-ALU stage for the address, then two data-memory stages. A floating-point add uses three FP stages. Every path ends in two write-back stages.

The unit keeps an age-indexed record of each instruction that has left decode: its opcode, whether it writes a register, and which register. An age of 0 means the first register-read stage. For each source operand it finds the youngest in-flight writer of that register. It then compares the writer's age against the cycle in which the operand is needed. A parameter picks the mode at build time: with no bypassing a consumer waits until its producer has left the last write-back stage, and with full bypassing it waits only until the result exists. While stalled, the unit holds decode and everything before it, and a bubble enters the first register-read stage.

Top module: `pipe_interlock`

## Requirements
- R1: After reset no instruction is in flight, so an instruction in decode is not stalled. The forwarding codes read 0 (register file) whenever no instruction issues.
- R2: With BYPASS=0, a consumer that reads the destination of the instruction issued just before it stalls for a number of cycles that depends only on the producer. The count is 4 after an integer add (opcode 0) and 6 after a load (opcode 1) or a floating-point add (opcode 3). Both of its forwarding codes are 0.
- R3: With BYPASS=1, an integer add that depends on the integer add just before it issues without a stall. Its forwarding code is 1 (integer-ALU result).
- R4: With BYPASS=1, a load whose address register is written by the floating-point add just before it stalls 2 cycles. Its address operand gets forwarding code 3 (third FP-stage result).
- R5: With BYPASS=1, a store (opcode 2) after a load stalls 2 cycles when the load supplies the store's address (operand A). It stalls 1 cycle when the load supplies the store's data (operand B). The forwarded operand gets code 2 (second data-memory result).
- R6: With BYPASS=1, a store whose data (operand B) comes from the floating-point add just before it stalls 1 cycle. Operand B gets code 3.
- R7: A stalled instruction issues exactly once, in the first cycle its hazards clear. A bubble occupies the first register-read stage in the cycle after every stall cycle, and the in-flight record advances one stage per cycle.
- R8: When several in-flight instructions write the same register, only the youngest one sets the stall and the forwarding code.
- R9: A store writes no register, so a later read of the store's destination field neither stalls nor forwards. Operand B of a load is unused and never stalls or forwards.
- R10: Instructions with no true data dependency never stall, even when several write-backs complete in the same cycle. The unit stalls only when some operand has an in-flight writer.
- R11: With BYPASS=1, an operand whose producer will already be past its last write-back when the operand is needed gets code 0. If the producer is still in flight at that point, the operand gets the producer's code. Independent instructions issued between producer and consumer reduce the stall one for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_op | input | 2 | Opcode: 0 integer add, 1 load, 2 store, 3 FP add |
| dec_src_a | input | $clog2(NREG) | Operand A register (ALU input or memory address) |
| dec_src_b | input | $clog2(NREG) | Operand B register (second ALU input or store data) |
| dec_dst | input | $clog2(NREG) | Destination register (ignored for stores) |
| stall | output | 1 | Hold decode and earlier stages this cycle |
| issue | output | 1 | The decode instruction moves into the first register-read stage |
| fwd_a | output | 2 | Operand A source at issue: 0 register file, 1 integer ALU, 2 data memory, 3 FP unit |
| fwd_b | output | 2 | Operand B source at issue, same encoding |

## Verification
The assertions assume that whoever drives decode holds its instruction fields steady while stall is high and only changes them after a cycle with issue set. They also assume the opcode is one of the four listed values. The bench's driver task keeps to this: it sets all decode fields after a rising edge and keeps them until it has seen issue, and it drops dec_valid between instructions. Between producer/consumer pairs, the bench leaves idle cycles long enough to empty the longest path, so that each pair's stall count comes only from the two instructions under test.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;

  typedef enum logic [1:0] {
    OP_IADD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_FADD  = 2'd3
  } op_e;

  localparam logic [1:0] FWD_RF  = 2'd0;
  localparam logic [1:0] FWD_INT = 2'd1;
  localparam logic [1:0] FWD_MEM = 2'd2;
  localparam logic [1:0] FWD_FP  = 2'd3;

  // Age (0 = first register-read stage) of the final write-back stage.
  function automatic int last_age(logic [1:0] op, int rr, int mem, int fp, int wb);
    case (op)
      OP_IADD:  return rr + 1 + wb - 1;
      OP_FADD:  return rr + fp + wb - 1;
      default:  return rr + 1 + mem + wb - 1;
    endcase
  endfunction

  // Age of the stage at whose end the result can be forwarded.
  function automatic int ready_age(logic [1:0] op, int rr, int mem, int fp);
    case (op)
      OP_IADD:  return rr;
      OP_LOAD:  return rr + mem;
      OP_FADD:  return rr + fp - 1;
      default:  return 0;
    endcase
  endfunction

  // Age at whose start the operand is consumed; store data is one stage later.
  function automatic int need_age(logic late, int rr);
    return late ? rr + 1 : rr;
  endfunction

  // Producer age the consumer must wait for before it may issue.
  function automatic int wait_age(logic [1:0] op, int need, int byp,
                                  int rr, int mem, int fp, int wb);
    int r;
    if (byp != 0) begin
      r = ready_age(op, rr, mem, fp) - need;
      return (r > 0) ? r : 0;
    end
    return last_age(op, rr, mem, fp, wb);
  endfunction

  function automatic int pipe_depth(int rr, int mem, int fp, int wb);
    int a;
    int b;
    a = last_age(OP_LOAD, rr, mem, fp, wb);
    b = last_age(OP_FADD, rr, mem, fp, wb);
    return ((a > b) ? a : b) + 1;
  endfunction

  function automatic logic writes_reg(logic [1:0] op);
    return op != OP_STORE;
  endfunction

  function automatic logic reads_b(logic [1:0] op);
    return op != OP_LOAD;
  endfunction

  function automatic logic [1:0] fwd_code(logic [1:0] op);
    case (op)
      OP_IADD: return FWD_INT;
      OP_LOAD: return FWD_MEM;
      OP_FADD: return FWD_FP;
      default: return FWD_RF;
    endcase
  endfunction

endpackage

// File: rtl/pipe_ilk_track.sv
module pipe_ilk_track
  import pipe_ilk_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int RW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic          ins_wr,
  input  logic [1:0]    ins_op,
  input  logic [RW-1:0] ins_dst,
  output logic          slot_vld  [DEPTH],
  output logic          slot_live [DEPTH],
  output logic [1:0]    slot_op   [DEPTH],
  output logic [RW-1:0] slot_dst  [DEPTH]
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_vld[0]  <= 1'b0;
          slot_live[0] <= 1'b0;
          slot_op[0]   <= OP_IADD;
          slot_dst[0]  <= '0;
        end else begin
          slot_vld[0]  <= ins_valid;
          slot_live[0] <= ins_valid & ins_wr;
          slot_op[0]   <= ins_op;
          slot_dst[0]  <= ins_dst;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_vld[k]  <= 1'b0;
          slot_live[k] <= 1'b0;
          slot_op[k]   <= OP_IADD;
          slot_dst[k]  <= '0;
        end else begin
          slot_vld[k]  <= slot_vld[k-1];
          slot_live[k] <= slot_live[k-1];
          slot_op[k]   <= slot_op[k-1];
          slot_dst[k]  <= slot_dst[k-1];
        end
      end

      // R7
      adv_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[k] == $past(slot_vld[k-1]));
    end

    // R9
    store_nodst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[k] && slot_op[k] == OP_STORE) |-> !slot_live[k]);
  end

endmodule

// File: rtl/pipe_ilk_hazard.sv
module pipe_ilk_hazard
  import pipe_ilk_pkg::*;
#(
  parameter int DEPTH      = 7,
  parameter int RW         = 5,
  parameter int BYPASS     = 0,
  parameter int RR_STAGES  = 2,
  parameter int MEM_STAGES = 2,
  parameter int FP_STAGES  = 3,
  parameter int WB_STAGES  = 2
) (
  input  logic          used,
  input  logic          late,
  input  logic [RW-1:0] src,
  input  logic          slot_live [DEPTH],
  input  logic [1:0]    slot_op   [DEPTH],
  input  logic [RW-1:0] slot_dst  [DEPTH],
  output logic          hit,
  output logic          need_stall,
  output logic [1:0]    fwd
);

  int         hit_age;
  int         need;
  int         wait_for;
  logic [1:0] prod_op;

  // Youngest writer wins: scan from oldest to youngest, last match kept.
  always_comb begin
    hit     = 1'b0;
    hit_age = 0;
    prod_op = OP_IADD;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (slot_live[k] && slot_dst[k] == src) begin
        hit     = used;
        hit_age = k;
        prod_op = slot_op[k];
      end
    end
  end

  always_comb begin
    need       = need_age(late, RR_STAGES);
    wait_for   = wait_age(prod_op, need, BYPASS, RR_STAGES, MEM_STAGES,
                          FP_STAGES, WB_STAGES);
    need_stall = hit && (hit_age < wait_for);
    fwd        = FWD_RF;
    if (BYPASS != 0 && hit &&
        (hit_age + 1 + need <= last_age(prod_op, RR_STAGES, MEM_STAGES,
                                        FP_STAGES, WB_STAGES)))
      fwd = fwd_code(prod_op);
  end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_ilk_pkg::*;
#(
  parameter int NREG       = 32,
  parameter int BYPASS     = 0,
  parameter int RR_STAGES  = 2,
  parameter int MEM_STAGES = 2,
  parameter int FP_STAGES  = 3,
  parameter int WB_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_valid,
  input  logic [1:0]              dec_op,
  input  logic [$clog2(NREG)-1:0] dec_src_a,
  input  logic [$clog2(NREG)-1:0] dec_src_b,
  input  logic [$clog2(NREG)-1:0] dec_dst,
  output logic                    stall,
  output logic                    issue,
  output logic [1:0]              fwd_a,
  output logic [1:0]              fwd_b
);

  localparam int RW    = $clog2(NREG);
  localparam int DEPTH = pipe_depth(RR_STAGES, MEM_STAGES, FP_STAGES, WB_STAGES);
  localparam int RUNW  = $clog2(DEPTH) + 1;

  logic          slot_vld  [DEPTH];
  logic          slot_live [DEPTH];
  logic [1:0]    slot_op   [DEPTH];
  logic [RW-1:0] slot_dst  [DEPTH];

  logic [RW-1:0] opnd_src   [2];
  logic          opnd_used  [2];
  logic          opnd_late  [2];
  logic          opnd_hit   [2];
  logic          opnd_stall [2];
  logic [1:0]    opnd_fwd   [2];

  assign opnd_src[0]  = dec_src_a;
  assign opnd_src[1]  = dec_src_b;
  assign opnd_used[0] = dec_valid;
  assign opnd_used[1] = dec_valid & reads_b(dec_op);
  assign opnd_late[0] = 1'b0;
  assign opnd_late[1] = (dec_op == OP_STORE);

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    pipe_ilk_hazard #(
      .DEPTH(DEPTH), .RW(RW), .BYPASS(BYPASS), .RR_STAGES(RR_STAGES),
      .MEM_STAGES(MEM_STAGES), .FP_STAGES(FP_STAGES), .WB_STAGES(WB_STAGES)
    ) u_haz (
      .used(opnd_used[i]), .late(opnd_late[i]), .src(opnd_src[i]),
      .slot_live(slot_live), .slot_op(slot_op), .slot_dst(slot_dst),
      .hit(opnd_hit[i]), .need_stall(opnd_stall[i]), .fwd(opnd_fwd[i])
    );
  end

  assign stall = opnd_stall[0] | opnd_stall[1];
  assign issue = dec_valid & ~stall;
  assign fwd_a = issue ? opnd_fwd[0] : FWD_RF;
  assign fwd_b = issue ? opnd_fwd[1] : FWD_RF;

  pipe_ilk_track #(.DEPTH(DEPTH), .RW(RW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(issue), .ins_wr(writes_reg(dec_op)), .ins_op(dec_op),
    .ins_dst(dec_dst),
    .slot_vld(slot_vld), .slot_live(slot_live), .slot_op(slot_op),
    .slot_dst(slot_dst)
  );

  // Consecutive stall cycles seen so far, for the bound check.
  logic [RUNW-1:0] stall_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_run <= '0;
    else        stall_run <= stall ? stall_run + 1'b1 : '0;
  end

  // R7
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !slot_vld[0]);

  // R2
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_run < RUNW'(DEPTH - 1)));

  // R10
  no_false_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !opnd_hit[0] && !opnd_hit[1]) |-> issue);

  // R1
  idle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (fwd_a == FWD_RF && fwd_b == FWD_RF && !stall));

endmodule

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       dv [2];
  logic [1:0] opc [2];
  logic [4:0] sa [2];
  logic [4:0] sb [2];
  logic [4:0] sd [2];
  logic       st [2];
  logic       is [2];
  logic [1:0] fa [2];
  logic [1:0] fb [2];

  pipe_interlock #(.BYPASS(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dv[0]), .dec_op(opc[0]),
    .dec_src_a(sa[0]), .dec_src_b(sb[0]), .dec_dst(sd[0]),
    .stall(st[0]), .issue(is[0]), .fwd_a(fa[0]), .fwd_b(fb[0]));

  pipe_interlock #(.BYPASS(1)) u_dut_byp (
    .clk(clk), .rst_n(rst_n), .dec_valid(dv[1]), .dec_op(opc[1]),
    .dec_src_a(sa[1]), .dec_src_b(sb[1]), .dec_dst(sd[1]),
    .stall(st[1]), .issue(is[1]), .fwd_a(fa[1]), .fwd_b(fb[1]));

  typedef struct { int stalls; int ea; int eb; string tag; } exp_t;
  exp_t q[$];
  int errs = 0;
  int checks = 0;
  int cur = 0;
  int scnt = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: counts stall cycles of the decode instruction, compares on issue.
  always @(negedge clk) begin
    if (rst_n && dv[cur]) begin
      if (st[cur]) scnt++;
      else if (is[cur]) begin
        if (q.size() == 0) check("unexpected issue", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " stalls"}, scnt, e.stalls);
          check({e.tag, " fwd_a"}, int'(fa[cur]), e.ea);
          check({e.tag, " fwd_b"}, int'(fb[cur]), e.eb);
        end
        scnt = 0;
      end
    end
  end

  // Reference model: path length L after the read stages (ALU=1, ALU+2 mem=3, 3 FP=3).
  function automatic int exec_len(int op);
    return (op == 0) ? 1 : 3;
  endfunction
  function automatic int need_of(bit data);
    return data ? 3 : 2;
  endfunction
  function automatic int ref_req(int op, bit data, int byp);
    int r;
    if (byp == 0) return exec_len(op) + 3;
    r = exec_len(op) + 1 - need_of(data);
    return (r > 0) ? r : 0;
  endfunction
  function automatic int ref_fwd(int op, bit data, int byp, int k);
    if (byp != 0 && k + 1 + need_of(data) <= exec_len(op) + 3) return op + 1 - ((op == 3) ? 1 : 0);
    return 0;
  endfunction

  task automatic send(int m, int op, int a, int b, int d, int es, int ea, int eb, string tag);
    exp_t e;
    e.stalls = es; e.ea = ea; e.eb = eb; e.tag = tag;
    q.push_back(e);
    cur = m;
    dv[m] = 1'b1; opc[m] = 2'(op); sa[m] = 5'(a); sb[m] = 5'(b); sd[m] = 5'(d);
    do @(negedge clk); while (!is[m]);
    @(posedge clk); #1;
    dv[m] = 1'b0;
  endtask

  task automatic flush();
    repeat (10) @(posedge clk);
    #1;
  endtask

  // Producer, gap independent fillers, then consumer; expectations from the model.
  task automatic pair(int m, int pop, int pr, int gap, int cop, int ca, int cb, int cd, string tag);
    bit da, db, bdat;
    int s, sa_n, sb_n, k;
    flush();
    send(m, pop, 25, 26, pr, 0, 0, 0, {tag, " producer"});
    for (int g = 0; g < gap; g++) send(m, 0, 28, 29, 30, 0, 0, 0, {tag, " filler"});
    da = (ca == pr);
    db = (cop != 1) && (cb == pr);
    bdat = (cop == 2);
    sa_n = da ? ref_req(pop, 1'b0, m) - gap : 0;
    sb_n = db ? ref_req(pop, bdat, m) - gap : 0;
    s = (sa_n > sb_n) ? sa_n : sb_n;
    if (s < 0) s = 0;
    k = gap + s;
    send(m, cop, ca, cb, cd, s,
         da ? ref_fwd(pop, 1'b0, m, k) : 0,
         db ? ref_fwd(pop, bdat, m, k) : 0, tag);
  endtask

  bit done = 1'b0;
  initial begin
    #(5 * 100000);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      dv[m] = 1'b0; opc[m] = '0; sa[m] = '0; sb[m] = '0; sd[m] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 stall after reset (no bypass)", int'(st[0]), 0);
    check("R1 stall after reset (bypass)", int'(st[1]), 0);
    check("R1 fwd_a idle", int'(fa[1]), 0);
    @(posedge clk); #1;

    for (int m = 0; m < 2; m++) begin
      send(m, 0, 1, 2, 3, 0, 0, 0, "R1 first instruction");
      // R2 / R3 integer add into dependent integer add
      pair(m, 0, 4, 0, 0, 4, 5, 6, "R2 R3 iadd->iadd");
      pair(m, 0, 4, 0, 3, 4, 4, 7, "R2 R3 iadd->fadd both operands");
      // R2 / R4 FP add feeding a load address; load operand B unused (R9)
      pair(m, 3, 8, 0, 1, 8, 8, 9, "R2 R4 R9 fadd->load addr");
      // R5 load feeding store address, then store data
      pair(m, 1, 10, 0, 2, 10, 11, 12, "R2 R5 load->store addr");
      pair(m, 1, 10, 0, 2, 11, 10, 12, "R2 R5 load->store data");
      // R6 FP add feeding store data
      pair(m, 3, 13, 0, 2, 14, 13, 15, "R2 R6 fadd->store data");
      // R11 window: fillers between producer and consumer
      pair(m, 0, 16, 1, 0, 16, 17, 18, "R11 iadd gap1");
      pair(m, 0, 16, 3, 0, 16, 17, 18, "R11 iadd gap3");
      pair(m, 1, 16, 2, 2, 17, 16, 18, "R11 load gap2 store data");
      pair(m, 3, 16, 5, 3, 16, 17, 18, "R11 fadd gap5");

      // R8 youngest writer decides: load r5, iadd r5, consumer reads r5
      flush();
      send(m, 1, 25, 26, 5, 0, 0, 0, "R8 older load");
      send(m, 0, 28, 29, 5, 0, 0, 0, "R8 younger iadd same dst");
      send(m, 0, 5, 28, 31, ref_req(0, 1'b0, m), ref_fwd(0, 1'b0, m, ref_req(0, 1'b0, m)), 0,
           "R8 consumer of r5");

      // R9 store writes nothing
      flush();
      send(m, 2, 1, 2, 7, 0, 0, 0, "R9 store");
      send(m, 0, 7, 7, 8, 0, 0, 0, "R9 read of store dst field");

      // R10 independent burst, several write-backs finishing together
      flush();
      send(m, 1, 1, 2, 19, 0, 0, 0, "R10 load");
      send(m, 3, 3, 4, 20, 0, 0, 0, "R10 fadd");
      send(m, 0, 5, 6, 21, 0, 0, 0, "R10 iadd");
      send(m, 2, 1, 2, 22, 0, 0, 0, "R10 store");
      send(m, 0, 23, 24, 18, 0, 0, 0, "R10 iadd");

      // R7 stalled instruction issues once, next one follows without extra wait
      flush();
      send(m, 1, 25, 26, 9, 0, 0, 0, "R7 load");
      send(m, 0, 9, 28, 10, ref_req(1, 1'b0, m), ref_fwd(1, 1'b0, m, ref_req(1, 1'b0, m)), 0,
           "R7 dependent iadd");
      send(m, 0, 1, 2, 11, 0, 0, 0, "R7 follower");
      flush();
      check("R7 all expected issues seen", q.size(), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule